// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a 16-bit processor core and byte-wide external program and data memory. The address space is 20 bits wide. The low address byte and the data byte share one bidirectional bus. The middle and top address bits leave on two dedicated output groups. An address latch strobe marks the address phase. Separate active-low strobes serve instruction fetches and data reads and writes. A wait input from slow data memory can stretch an access.

The core issues a one-cycle request while the controller is idle. The controller then runs the bus cycle, measured in oscillator phases (one clock per phase), and returns a one-cycle ready pulse together with any read byte. A level on the boot-mode pin decides where program fetches go. With the pin high, the lower 64 KB of program space is served by on-chip ROM and the controller only signals that selection. With the pin low, every fetch goes out to the bus, and the upper address and strobe pin functions are enabled whatever the pin configuration says. During a data access, the top four address bits carry a segment value from the core.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, ale_o is 0, psen_n_o, rd_n_o and wr_n_o are 1, ad_oe_o is 0, ready_o and rom_sel_o are 0.
- R2: With ea_i = 1, a fetch whose address is below 10000h causes no bus activity. ready_o and rom_sel_o are both 1 in the cycle after the request.
- R3: With ea_i = 1, a fetch at 10000h or above runs an external bus cycle. With ea_i = 0, every fetch runs one, including addresses below 10000h.
- R4: ale_o is high for exactly the first phase after the request, and during that phase ad_o drives address bits 7:0 with ad_oe_o = 1. a_mid_o carries address bits 15:8. a_hi_o carries address bits 19:16 for a fetch and seg_i for a data access.
- R5: In an external fetch, psen_n_o is low for phases 5 and 6 after the request, so the upper address has been out for four phases before it falls. rd_n_o and wr_n_o stay high. ready_o is 1 in phase 7, and rdata_o then holds the ad_i byte sampled in the last strobe phase.
- R6: In a data read, rd_n_o is low for phases 4 and 5 and ready_o is 1 in phase 6. ad_oe_o is 0 from phase 2 until the end of the access.
- R7: In a data write, wr_n_o is low for phases 4 and 5 and ready_o is 1 in phase 6. From phase 2 through phase 5, ad_o carries wdata_i with ad_oe_o = 1.
- R8: wait_i is sampled in the last strobe phase of a data access. While it is 1, that phase repeats, so dropping wait_i at phase k (k ≥ 5) gives ready_o at phase k+1. wait_i has no effect on a fetch.
- R9: a_up_oe_o equals cfg_addr_en_i and ctl_oe_o equals cfg_ctl_en_i while ea_i = 1. Both are 1 while ea_i = 0.
- R10: A request that arrives while busy_o is 1 is ignored. It produces no bus cycle, no ready_o and no rom_sel_o.
- R11: ready_o is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_i | input | 1 | Boot-mode pin: 1 = low 64 KB of program space internal |
| cfg_addr_en_i | input | 1 | Pin configuration: upper address function enabled |
| cfg_ctl_en_i | input | 1 | Pin configuration: ALE/program strobe function enabled |
| req_i | input | 1 | One-cycle access request from the core |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| write_i | input | 1 | 1 = data write (data access only) |
| addr_i | input | 20 | Access address |
| seg_i | input | 4 | Segment bits placed on a_hi_o during data accesses |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read or fetched byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rom_sel_o | output | 1 | Fetch served by internal ROM (with ready_o) |
| busy_o | output | 1 | External bus cycle in progress |
| ad_o | output | 8 | Multiplexed low address / data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 8 | Multiplexed bus input |
| a_mid_o | output | 8 | Address bits 15:8 |
| a_hi_o | output | 4 | Address bits 19:16 or segment |
| a_up_oe_o | output | 1 | Upper address pin function active |
| ctl_oe_o | output | 1 | ALE / program strobe pin function active |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Program fetch strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| wait_i | input | 1 | Stretch request from data memory |

## Verification
The bench builds the controller with its default parameters: a 20-bit address, a 16-bit internal boundary, a four-phase fetch setup, a three-phase data setup and a two-phase strobe. With these values, the 0FFFFh/10000h split and both strobe placements can be reached with short directed accesses. Each access is traced phase by phase against an external latch and memory model, so address demultiplexing, bus release and write drive windows are visible at the pins. Wait stretching, a request during a busy cycle and the forcing effect of the boot pin are all covered within a few dozen cycles.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_SETUP = 2'd2,
    ST_STRB  = 2'd3
  } ebc_state_e;
endpackage

// File: rtl/ebc_route.sv
module ebc_route #(
  parameter int ADDR_W = 20,
  parameter int INT_W  = 16
) (
  input  logic              ea_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              external_o
);
  logic above_int;
  assign above_int  = |addr_i[ADDR_W-1:INT_W];
  // data accesses arriving here are always external; fetches depend on the boot pin
  assign external_o = !fetch_i || !ea_i || above_int;
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int FETCH_SETUP = 4,
  parameter int DATA_SETUP  = 3,
  parameter int STROBE_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       fetch_i,
  input  logic       wait_i,
  output ebc_state_e state_o,
  output logic       done_o
);
  localparam int MAXP  = (FETCH_SETUP > DATA_SETUP) ?
                         ((FETCH_SETUP > STROBE_LEN) ? FETCH_SETUP : STROBE_LEN) :
                         ((DATA_SETUP > STROBE_LEN) ? DATA_SETUP : STROBE_LEN);
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam logic [CNT_W-1:0] F_LD = CNT_W'(FETCH_SETUP - 2);
  localparam logic [CNT_W-1:0] D_LD = CNT_W'(DATA_SETUP - 2);
  localparam logic [CNT_W-1:0] S_LD = CNT_W'(STROBE_LEN - 1);

  ebc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hold;

  assign hold = !fetch_i && wait_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: begin
        state_d = ST_SETUP;
        cnt_en  = 1'b1;
        cnt_d   = fetch_i ? F_LD : D_LD;
      end
      ST_SETUP: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_STRB;
          cnt_d   = S_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STRB: begin
        if (cnt_q != '0) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end else if (!hold) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ebc_state_e        state_i,
  input  logic              fetch_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  logic in_addr, in_data, in_strb;
  assign in_addr = (state_i == ST_ADDR);
  assign in_data = (state_i == ST_SETUP) || (state_i == ST_STRB);
  assign in_strb = (state_i == ST_STRB);

  always_comb begin
    ale_o    = in_addr;
    ad_o     = in_addr ? addr_lo_i : wdata_i;
    ad_oe_o  = in_addr || (in_data && !fetch_i && write_i);
    psen_n_o = !(in_strb && fetch_i);
    rd_n_o   = !(in_strb && !fetch_i && !write_i);
    wr_n_o   = !(in_strb && !fetch_i && write_i);
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int INT_W       = 16,
  parameter int SEG_W       = 4,
  parameter int FETCH_SETUP = 4,
  parameter int DATA_SETUP  = 3,
  parameter int STROBE_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ea_i,
  input  logic              cfg_addr_en_i,
  input  logic              cfg_ctl_en_i,
  input  logic              req_i,
  input  logic              fetch_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              rom_sel_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] a_mid_o,
  output logic [SEG_W-1:0]  a_hi_o,
  output logic              a_up_oe_o,
  output logic              ctl_oe_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  input  logic              wait_i
);
  localparam int MID_W = INT_W - DATA_W;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ebc_state_e        state;
  logic              idle, external, start, int_hit, done;
  logic              fetch_q, write_q;
  logic [DATA_W-1:0] lo_q, wdata_q, rdata_q;
  logic [MID_W-1:0]  mid_q;
  logic [SEG_W-1:0]  hi_q, hi_d;
  logic              ready_q, rom_sel_q;
  logic              cap_en;

  assign idle    = (state == ST_IDLE);
  assign start   = req_i && idle && external;
  assign int_hit = req_i && idle && !external;
  assign hi_d    = fetch_i ? addr_i[ADDR_W-1:INT_W] : seg_i;
  assign cap_en  = done && !write_q;

  ebc_route #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_route (
    .ea_i      (ea_i),
    .fetch_i   (fetch_i),
    .addr_i    (addr_i),
    .external_o(external)
  );

  ebc_seq #(
    .FETCH_SETUP(FETCH_SETUP),
    .DATA_SETUP (DATA_SETUP),
    .STROBE_LEN (STROBE_LEN)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start_i(start),
    .fetch_i(fetch_q),
    .wait_i (wait_i),
    .state_o(state),
    .done_o (done)
  );

  ebc_pins #(.DATA_W(DATA_W)) u_pins (
    .state_i  (state),
    .fetch_i  (fetch_q),
    .write_i  (write_q),
    .addr_lo_i(lo_q),
    .wdata_i  (wdata_q),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fetch_q   <= 1'b0;
      write_q   <= 1'b0;
      lo_q      <= '0;
      mid_q     <= '0;
      hi_q      <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      ready_q   <= 1'b0;
      rom_sel_q <= 1'b0;
    end else begin
      if (start) begin
        fetch_q <= fetch_i;
        write_q <= write_i && !fetch_i;
        lo_q    <= addr_i[DATA_W-1:0];
        mid_q   <= addr_i[INT_W-1:DATA_W];
        hi_q    <= hi_d;
        wdata_q <= wdata_i;
      end
      if (cap_en) rdata_q <= ad_i;
      ready_q   <= done || int_hit;
      rom_sel_q <= int_hit;
    end
  end

  assign rdata_o   = rdata_q;
  assign ready_o   = ready_q;
  assign rom_sel_o = rom_sel_q;
  assign busy_o    = !idle;
  assign a_mid_o   = mid_q;
  assign a_hi_o    = hi_q;
  assign a_up_oe_o = cfg_addr_en_i || !ea_i;
  assign ctl_oe_o  = cfg_ctl_en_i || !ea_i;
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ale_o,
  input logic psen_n_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic ad_oe_o,
  input logic ready_o,
  input logic wait_i
);
  // R4
  ale_one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n_o, ~rd_n_o, ~wr_n_o}) <= 1);

  // R5
  psen_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n_o) |=> !psen_n_o);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe_o);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o && wait_i && $past(!rd_n_o)) |=> !rd_n_o);

  // R4
  ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (psen_n_o && rd_n_o && wr_n_o));
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_ext_bus_ctrl_chk (.*);

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ea_i, cfg_addr_en_i, cfg_ctl_en_i;
  logic        req_i, fetch_i, write_i;
  logic [19:0] addr_i;
  logic [3:0]  seg_i;
  logic [7:0]  wdata_i, rdata_o;
  logic        ready_o, rom_sel_o, busy_o;
  logic [7:0]  ad_o, ad_i, a_mid_o;
  logic        ad_oe_o;
  logic [3:0]  a_hi_o;
  logic        a_up_oe_o, ctl_oe_o, ale_o, psen_n_o, rd_n_o, wr_n_o, wait_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_bus_ctrl i_ext_bus_ctrl (.*);

  // external address latch and memory model
  logic [7:0] lat;
  always @(negedge clk) if (ale_o) lat <= ad_o;
  assign ad_i = (!psen_n_o || !rd_n_o) ? (lat ^ 8'h5A) : 8'h00;

  // phase trace
  logic       t_ale[0:31], t_psen[0:31], t_rd[0:31], t_wr[0:31], t_oe[0:31], t_rdy[0:31], t_rom[0:31];
  logic [7:0] t_ad[0:31], t_mid[0:31];
  logic [3:0] t_hi[0:31];
  int         rdy_at;
  logic       rdy_after;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // runs one access; wrel>0 drops wait_i at that phase; inj>0 raises a second request there
  task automatic do_access(input logic f, input logic w, input logic [19:0] a,
                           input logic [3:0] s, input logic [7:0] d,
                           input int wrel, input int inj);
    @(negedge clk);
    req_i = 1; fetch_i = f; write_i = w; addr_i = a; seg_i = s; wdata_i = d;
    rdy_at = 0;
    for (int i = 1; i < 30; i++) begin
      @(negedge clk);
      req_i = 0;
      t_ale[i] = ale_o; t_psen[i] = psen_n_o; t_rd[i] = rd_n_o; t_wr[i] = wr_n_o;
      t_oe[i] = ad_oe_o; t_rdy[i] = ready_o; t_rom[i] = rom_sel_o;
      t_ad[i] = ad_o; t_mid[i] = a_mid_o; t_hi[i] = a_hi_o;
      if (i == wrel) wait_i = 0;
      if (i == inj) begin
        req_i = 1; fetch_i = 1; write_i = 0; addr_i = 20'h00010;
      end
      if (ready_o) begin
        rdy_at = i;
        break;
      end
    end
    @(negedge clk);
    rdy_after = ready_o;
  endtask

  task automatic t_reset();
    chk("R1 ale", ale_o, 0);
    chk("R1 strobes", {psen_n_o, rd_n_o, wr_n_o}, 3'b111);
    chk("R1 ad_oe", ad_oe_o, 0);
    chk("R1 ready/rom_sel", {ready_o, rom_sel_o}, 2'b00);
  endtask

  task automatic t_int_fetch();
    ea_i = 1;
    do_access(1, 0, 20'h0FFFF, 4'h0, 8'h00, 0, 0);
    chk("R2 ready phase", rdy_at, 1);
    chk("R2 rom_sel", t_rom[1], 1);
    chk("R2 no ale", t_ale[1], 0);
    chk("R11 ready one cycle", rdy_after, 0);
  endtask

  task automatic t_ext_fetch();
    ea_i = 1;
    do_access(1, 0, 20'h1ABCD, 4'h0, 8'h00, 0, 0);
    chk("R3 boundary external", rdy_at, 7);
    chk("R2 rom_sel low external", t_rom[7], 0);
    chk("R4 ale phase1", t_ale[1], 1);
    chk("R4 ale phase2", t_ale[2], 0);
    chk("R4 low addr", {t_oe[1], t_ad[1]}, {1'b1, 8'hCD});
    chk("R4 mid addr", t_mid[1], 8'hAB);
    chk("R4 hi addr", t_hi[1], 4'h1);
    for (int i = 1; i <= 7; i++)
      chk($sformatf("R5 psen phase %0d", i), t_psen[i], (i == 5 || i == 6) ? 1'b0 : 1'b1);
    for (int i = 1; i <= 7; i++)
      chk($sformatf("R5 rd/wr idle phase %0d", i), {t_rd[i], t_wr[i]}, 2'b11);
    for (int i = 2; i <= 6; i++)
      chk($sformatf("R5 bus released phase %0d", i), t_oe[i], 0);
    chk("R5 rdata", rdata_o, 8'hCD ^ 8'h5A);
    chk("R11 ready one cycle", rdy_after, 0);
  endtask

  task automatic t_ea_low();
    ea_i = 1; cfg_addr_en_i = 0; cfg_ctl_en_i = 0;
    #1;
    chk("R9 cfg off ea high", {a_up_oe_o, ctl_oe_o}, 2'b00);
    cfg_addr_en_i = 1;
    #1;
    chk("R9 cfg addr on", {a_up_oe_o, ctl_oe_o}, 2'b10);
    cfg_addr_en_i = 0;
    ea_i = 0;
    #1;
    chk("R9 forced by ea low", {a_up_oe_o, ctl_oe_o}, 2'b11);
    do_access(1, 0, 20'h00123, 4'h0, 8'h00, 0, 0);
    chk("R3 ea low external", rdy_at, 7);
    chk("R3 ea low ale", t_ale[1], 1);
    chk("R3 ea low no rom_sel", t_rom[7], 0);
    chk("R5 rdata ea low", rdata_o, 8'h23 ^ 8'h5A);
    ea_i = 1;
  endtask

  task automatic t_read();
    do_access(0, 0, 20'h30456, 4'h9, 8'h00, 0, 0);
    chk("R6 ready phase", rdy_at, 6);
    chk("R4 seg on hi", t_hi[1], 4'h9);
    chk("R4 mid data", t_mid[1], 8'h04);
    chk("R4 low data addr", t_ad[1], 8'h56);
    for (int i = 1; i <= 6; i++)
      chk($sformatf("R6 rd phase %0d", i), t_rd[i], (i == 4 || i == 5) ? 1'b0 : 1'b1);
    for (int i = 2; i <= 6; i++)
      chk($sformatf("R6 released phase %0d", i), t_oe[i], 0);
    chk("R6 psen idle", t_psen[4], 1);
    chk("R6 rdata", rdata_o, 8'h56 ^ 8'h5A);
  endtask

  task automatic t_write();
    do_access(0, 1, 20'h0BEEF, 4'h2, 8'hC3, 0, 0);
    chk("R7 ready phase", rdy_at, 6);
    chk("R4 write addr", {t_ale[1], t_ad[1]}, {1'b1, 8'hEF});
    for (int i = 1; i <= 6; i++)
      chk($sformatf("R7 wr phase %0d", i), t_wr[i], (i == 4 || i == 5) ? 1'b0 : 1'b1);
    for (int i = 2; i <= 5; i++)
      chk($sformatf("R7 data drive phase %0d", i), {t_oe[i], t_ad[i]}, {1'b1, 8'hC3});
    chk("R7 release after", t_oe[6], 0);
    chk("R11 ready one cycle", rdy_after, 0);
  endtask

  task automatic t_wait();
    wait_i = 1;
    do_access(0, 0, 20'h00077, 4'h0, 8'h00, 8, 0);
    chk("R8 stretched ready", rdy_at, 9);
    for (int i = 4; i <= 8; i++)
      chk($sformatf("R8 rd held phase %0d", i), t_rd[i], 0);
    chk("R8 rd released", t_rd[9], 1);
    chk("R8 rdata", rdata_o, 8'h77 ^ 8'h5A);
    wait_i = 1;
    do_access(1, 0, 20'h40011, 4'h0, 8'h00, 0, 0);
    chk("R8 fetch ignores wait", rdy_at, 7);
    wait_i = 0;
  endtask

  task automatic t_busy();
    int extra;
    do_access(0, 0, 20'h00200, 4'h0, 8'h00, 0, 2);
    chk("R10 first access done", rdy_at, 6);
    chk("R10 no rom_sel", t_rom[6], 0);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ready_o || ale_o || rom_sel_o || busy_o) extra++;
    end
    chk("R10 ignored request", extra, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ea_i = 1; cfg_addr_en_i = 0; cfg_ctl_en_i = 0;
    req_i = 0; fetch_i = 0; write_i = 0; addr_i = '0; seg_i = '0; wdata_i = '0; wait_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_int_fetch();
    t_ext_fetch();
    t_ea_low();
    t_read();
    t_write();
    t_wait();
    t_busy();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule